// File: doc/BRIEF.md
# Programmable Odd/Even Output Clock Divider

This block produces one divided clock output from one of two clock sources. Each source is a one-cycle enable pulse, called a tick, on a shared fast system clock. Each tick stands for one period of that source. A per-output source select picks either the synthesized-clock ticks or the reference-clock ticks. The selected ticks are divided by a 5-bit P value, which may be odd or even. An optional binary post stage then divides by 1, 2, 4 or 8, so the overall ratio is P times the post factor.

The output is a registered level. Its duty cycle is as even as the ratio allows. Settings are written into a shadow register through a single write strobe. The shadow is copied into the working settings only when an output period ends, so a change never cuts a period short.

Two build-time switches trim the block for outputs that need less. One removes the post stage, leaving a divide by P only. The other removes the source select and ties the output to the reference ticks.

Top module: `clkdiv_out`

## Requirements
- R1: A synchronous reset clears all counters and holds `div_out` low; the first selected tick after reset begins a period and drives `div_out` high in the following cycle.
- R2: With the post code at 0 and an even P of 2 or more, `div_out` is high for P/2 selected ticks and low for P/2 selected ticks, and the pattern repeats.
- R3: With the post code at 0 and an odd P of 3 or more, `div_out` is high for (P+1)/2 selected ticks and low for (P-1)/2 selected ticks.
- R4: With P equal to 0 or 1 and the post code at 0, the source passes straight through: `div_out` is high in exactly the cycle after each selected tick and low otherwise.
- R5: Post code k (0 to 3) divides by 2^k after the P stage. For k of 1 or more, `div_out` is high for the first 2^(k-1) P-periods of every 2^k P-periods and low for the rest.
- R6: `cfg_src` = 0 selects `syn_tick` and `cfg_src` = 1 selects `ref_tick`; ticks on the unselected input have no effect on `div_out`.
- R7: A configuration write lands in a shadow register and takes effect only at the next period boundary. A write made in the same cycle as a boundary tick waits for the following boundary.
- R8: Apart from the low return in pass-through mode, `div_out` changes only in the cycle after a selected tick.
- R9: With the post stage omitted, `cfg_post` is ignored and the ratio is P alone. With the source select omitted, only `ref_tick` drives the output and `cfg_src` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| syn_tick | input | 1 | Synthesized-clock enable pulse |
| ref_tick | input | 1 | Reference-clock enable pulse |
| cfg_we | input | 1 | Shadow configuration write strobe |
| cfg_p | input | P_W (5) | P divide value; 0 and 1 mean pass-through |
| cfg_post | input | POST_W (2) | Post divider code k, divide by 2^k |
| cfg_src | input | 1 | Source select: 0 synthesized, 1 reference |
| div_out | output | 1 | Divided clock level, registered |

## Verification
A configuration write can arrive in the same cycle as the tick that closes a period. The working settings are then loaded from the shadow while the shadow itself is being rewritten. The correct result is that the period just starting uses the older shadow contents, and the new value waits one more full period. The bench provokes this by issuing a run of writes with a tick attached in every cycle across a boundary, then a slower tick stream. A cycle-exact expectation model, written from the requirements, predicts which value reaches `div_out` in each cycle. Both a full instance and a trimmed instance are compared against that model in every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int P_W_DEF    = 5;
  parameter int POST_W_DEF = 2;

  typedef enum logic {
    SRC_SYN = 1'b0,
    SRC_REF = 1'b1
  } src_e;
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int P_W     = P_W_DEF,
  parameter int POST_W  = POST_W_DEF,
  parameter bit POST_EN = 1'b1,
  parameter bit MUX_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [P_W-1:0]    wr_p,
  input  logic [POST_W-1:0] wr_post,
  input  logic              wr_src,
  input  logic              load,
  output logic [P_W-1:0]    act_p,
  output logic [POST_W-1:0] act_post,
  output src_e              act_src
);
  logic [P_W-1:0]    sh_p;
  logic [POST_W-1:0] sh_post;
  src_e              sh_src;
  logic [POST_W-1:0] run_post;
  src_e              run_src;

  // shadow copy, written by the configuration strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_p    <= '0;
      sh_post <= '0;
      sh_src  <= SRC_SYN;
    end else if (wr_en) begin
      sh_p    <= wr_p;
      sh_post <= wr_post;
      sh_src  <= src_e'(wr_src);
    end
  end

  // working copy, loaded only at a period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      act_p    <= '0;
      run_post <= '0;
      run_src  <= SRC_SYN;
    end else if (load) begin
      act_p    <= sh_p;
      run_post <= sh_post;
      run_src  <= sh_src;
    end
  end

  generate
    if (POST_EN) begin : g_post
      assign act_post = run_post;
    end else begin : g_no_post
      assign act_post = '0;
    end
    if (MUX_EN) begin : g_mux
      assign act_src = run_src;
    end else begin : g_ref_only
      assign act_src = SRC_REF;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel
  import clkdiv_pkg::*;
#(
  parameter bit MUX_EN = 1'b1
) (
  input  logic syn_tick,
  input  logic ref_tick,
  input  src_e src,
  output logic sel_tick
);
  generate
    if (MUX_EN) begin : g_mux
      assign sel_tick = (src == SRC_REF) ? ref_tick : syn_tick;
    end else begin : g_ref_only
      logic unused_in;
      assign unused_in = syn_tick ^ src;
      assign sel_tick  = ref_tick;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq #(
  parameter int P_W    = 5,
  parameter int POST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [P_W-1:0]    p,
  input  logic [POST_W-1:0] post,
  output logic              boundary,
  output logic              div_out
);
  localparam int Q_W = (1 << POST_W) - 1;

  logic [P_W-1:0] pcnt, p_last, pn;
  logic [P_W:0]   p_eff, p_hi;
  logic [Q_W-1:0] qcnt, q_last, q_half, qn;
  logic           run, at_end, single, level;

  always_comb begin
    p_eff  = (p == '0) ? (P_W+1)'(1) : {1'b0, p};
    p_last = (p == '0) ? '0 : p - 1'b1;
    p_hi   = (p_eff + 1'b1) >> 1;
    q_last = Q_W'((Q_W'(1) << post) - 1'b1);
    q_half = (post == '0) ? '0 : (Q_W'(1) << (post - 1'b1));
    single = (p_eff == (P_W+1)'(1)) && (post == '0);
    at_end = (pcnt == p_last) && (qcnt == q_last);
    boundary = tick && (!run || at_end);
    if (pcnt == p_last) begin
      pn = '0;
      qn = qcnt + 1'b1;
    end else begin
      pn = pcnt + 1'b1;
      qn = qcnt;
    end
    level = (post == '0) ? ({1'b0, pn} < p_hi) : (qn < q_half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      qcnt    <= '0;
      run     <= 1'b0;
      div_out <= 1'b0;
    end else if (boundary) begin
      pcnt    <= '0;
      qcnt    <= '0;
      run     <= 1'b1;
      div_out <= 1'b1;
    end else if (tick) begin
      pcnt    <= pn;
      qcnt    <= qn;
      div_out <= level;
    end else if (single) begin
      div_out <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
#(
  parameter int P_W     = P_W_DEF,
  parameter int POST_W  = POST_W_DEF,
  parameter bit POST_EN = 1'b1,
  parameter bit MUX_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syn_tick,
  input  logic              ref_tick,
  input  logic              cfg_we,
  input  logic [P_W-1:0]    cfg_p,
  input  logic [POST_W-1:0] cfg_post,
  input  logic              cfg_src,
  output logic              div_out
);
  logic [P_W-1:0]    act_p;
  logic [POST_W-1:0] act_post;
  src_e              act_src;
  logic              sel_tick;
  logic              boundary;

  clkdiv_cfg #(.P_W(P_W), .POST_W(POST_W), .POST_EN(POST_EN), .MUX_EN(MUX_EN)) cfg_i (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_p(cfg_p), .wr_post(cfg_post),
    .wr_src(cfg_src), .load(boundary), .act_p(act_p), .act_post(act_post),
    .act_src(act_src)
  );

  clkdiv_src_sel #(.MUX_EN(MUX_EN)) sel_i (
    .syn_tick(syn_tick), .ref_tick(ref_tick), .src(act_src), .sel_tick(sel_tick)
  );

  clkdiv_seq #(.P_W(P_W), .POST_W(POST_W)) seq_i (
    .clk(clk), .rst(rst), .tick(sel_tick), .p(act_p), .post(act_post),
    .boundary(boundary), .div_out(div_out)
  );
endmodule

// File: rtl/clkdiv_out_chk.sv
module clkdiv_out_chk #(
  parameter int P_W    = 5,
  parameter int POST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_tick,
  input logic              boundary,
  input logic              div_out,
  input logic [P_W-1:0]    act_p,
  input logic [POST_W-1:0] act_post
);
  logic pass_mode;
  assign pass_mode = (act_p <= P_W'(1)) && (act_post == '0);

  // R1: reset forces the output low
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !div_out);

  // R1: every period opens with a high output
  p_start_high_r1: assert property (@(posedge clk) disable iff (rst)
    boundary |=> div_out);

  // R4: in pass-through mode the output drops when no tick arrives
  p_pass_low_r4: assert property (@(posedge clk) disable iff (rst)
    (pass_mode && !sel_tick) |=> !div_out);

  // R8: without a tick the output holds outside pass-through mode
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_tick && !pass_mode) |=> $stable(div_out));

  // R7: the working settings change only at a boundary
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(act_p) && $stable(act_post)));
endmodule

bind clkdiv_out clkdiv_out_chk #(.P_W(P_W), .POST_W(POST_W)) chk_i (
  .clk(clk), .rst(rst), .sel_tick(sel_tick), .boundary(boundary),
  .div_out(div_out), .act_p(act_p), .act_post(act_post)
);

// File: tb/clkdiv_out_tb_top.sv
module clkdiv_out_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       syn_tick = 1'b0, ref_tick = 1'b0, cfg_we = 1'b0, cfg_src = 1'b0;
  logic [4:0] cfg_p = '0;
  logic [1:0] cfg_post = '0;
  logic       out_full, out_fix;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clkdiv_out dut_i (
    .clk(clk), .rst(rst), .syn_tick(syn_tick), .ref_tick(ref_tick),
    .cfg_we(cfg_we), .cfg_p(cfg_p), .cfg_post(cfg_post), .cfg_src(cfg_src),
    .div_out(out_full)
  );

  clkdiv_out #(.POST_EN(1'b0), .MUX_EN(1'b0)) dut_fix_i (
    .clk(clk), .rst(rst), .syn_tick(syn_tick), .ref_tick(ref_tick),
    .cfg_we(cfg_we), .cfg_p(cfg_p), .cfg_post(cfg_post), .cfg_src(cfg_src),
    .div_out(out_fix)
  );

  typedef struct {
    bit    exp_full;
    bit    exp_fix;
    string tag;
  } item_t;
  item_t sb_q[$];

  // expectation model, index 0 full build, index 1 trimmed build
  bit m_mux [2] = '{1'b1, 1'b0};
  bit m_pen [2] = '{1'b1, 1'b0};
  bit m_run [2], m_out [2], m_asrc [2], m_ssrc [2];
  int m_pp [2], m_pq [2], m_ap [2], m_apost [2], m_sp [2], m_spost [2];

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_run[m] = 0; m_out[m] = 0; m_asrc[m] = 0; m_ssrc[m] = 0;
      m_pp[m] = 0; m_pq[m] = 0; m_ap[m] = 0; m_apost[m] = 0;
      m_sp[m] = 0; m_spost[m] = 0;
    end
  endtask

  task automatic model_step(int m, bit sy, bit rf, bit we, int wp, int wpost, bit wsrc);
    bit s;
    int e, f;
    s = m_mux[m] ? (m_asrc[m] ? rf : sy) : rf;
    e = (m_ap[m] == 0) ? 1 : m_ap[m];
    f = m_pen[m] ? (1 << m_apost[m]) : 1;
    if (s) begin
      if (!m_run[m] || (m_pp[m] == e - 1 && m_pq[m] == f - 1)) begin
        m_ap[m] = m_sp[m]; m_apost[m] = m_spost[m]; m_asrc[m] = m_ssrc[m];
        m_pp[m] = 0; m_pq[m] = 0; m_run[m] = 1; m_out[m] = 1;
      end else begin
        if (m_pp[m] == e - 1) begin
          m_pp[m] = 0; m_pq[m]++;
        end else m_pp[m]++;
        m_out[m] = (f == 1) ? (m_pp[m] < (e + 1) / 2) : (m_pq[m] < f / 2);
      end
    end else if (e == 1 && f == 1) m_out[m] = 0;
    if (we) begin
      m_sp[m] = wp; m_spost[m] = wpost; m_ssrc[m] = wsrc;
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the scoreboard
  task automatic cyc(bit sy, bit rf, bit we, int wp, int wpost, bit wsrc, string tag);
    item_t it;
    @(negedge clk);
    syn_tick = sy; ref_tick = rf; cfg_we = we;
    cfg_p = 5'(wp); cfg_post = 2'(wpost); cfg_src = wsrc;
    for (int m = 0; m < 2; m++) model_step(m, sy, rf, we, wp, wpost, wsrc);
    it.exp_full = m_out[0]; it.exp_fix = m_out[1]; it.tag = tag;
    sb_q.push_back(it);
  endtask

  int cur_p = 0, cur_post = 0;
  bit cur_src = 0;

  task automatic wr(int p, int post, bit src, string tag);
    cur_p = p; cur_post = post; cur_src = src;
    cyc(0, 0, 1, p, post, src, tag);
  endtask

  // n ticks on one source, gap cycles apart, optional ticks on the other one
  task automatic ticks(int n, int gap, bit on_ref, bit noise, string tag);
    for (int i = 0; i < n; i++) begin
      cyc(!on_ref, on_ref, 0, cur_p, cur_post, cur_src, tag);
      for (int g = 1; g < gap; g++)
        cyc(noise && on_ref, noise && !on_ref, 0, cur_p, cur_post, cur_src, tag);
    end
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    item_t it;
    #2;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      vectors++;
      if (out_full !== it.exp_full) begin
        fails++;
        $display("FAIL %s: full build div_out=%0b expected %0b", it.tag, out_full, it.exp_full);
      end
      if (out_fix !== it.exp_fix) begin
        fails++;
        $display("FAIL R9 (%s): trimmed build div_out=%0b expected %0b", it.tag, out_fix, it.exp_fix);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (out_full !== 1'b0 || out_fix !== 1'b0) begin
      fails++;
      $display("FAIL R1: div_out=%0b/%0b expected 0/0", out_full, out_fix);
    end
    rst = 1'b0;
    ticks(6, 3, 0, 1, "R4");              // reset defaults: pass-through
    wr(4, 0, 0, "R2");
    ticks(14, 2, 0, 0, "R2");
    wr(5, 0, 0, "R3");
    ticks(16, 3, 0, 1, "R3");
    wr(6, 0, 0, "R7");
    ticks(2, 2, 0, 0, "R7");
    wr(3, 0, 0, "R7");                     // mid-period write
    ticks(12, 2, 0, 0, "R7");
    for (int i = 0; i < 8; i++) begin     // writes colliding with boundary ticks
      cur_p = 2 + i; cur_post = i % 2;
      cyc(1, 0, 1, cur_p, cur_post, 0, "R7");
    end
    ticks(40, 2, 0, 0, "R7");
    wr(3, 2, 0, "R5");
    ticks(40, 1, 0, 0, "R5");
    wr(1, 3, 0, "R5");
    ticks(24, 2, 0, 0, "R5");
    wr(2, 1, 1, "R6");
    ticks(10, 2, 0, 0, "R6");
    ticks(24, 3, 1, 1, "R6");
    wr(1, 0, 0, "R4");
    ticks(4, 2, 1, 0, "R4");
    ticks(12, 1, 0, 0, "R4");
    ticks(6, 4, 0, 1, "R4");
    wr(7, 0, 0, "R8");
    for (int i = 0; i < 30; i++) ticks(1, 1 + (i % 4), 0, 0, "R8");
    wr(8, 2, 1, "R9");
    ticks(12, 2, 0, 0, "R9");
    ticks(80, 1, 1, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule